// File: doc/BRIEF.md
# Run-Time Width Exponent Datapath for a Floating-Point Multiplier

This block handles the exponent and sign half of a floating-point multiply whose exponent field width can change on every operation. A 2-bit format code picks a width of 5, 6, 7 or 8 bits. The block derives the matching bias from that code. It masks off the input exponent bits that lie above the chosen width, then adds the two operand exponents and removes the bias. In parallel it forms the same sum plus one, and the overflow flag from the significand path picks between the two.

The chosen sum is checked against the range of the selected width. A result at or below zero, or a zero operand field, raises a zero flag. A result at or above the all-ones field raises an infinity flag. A flush request tells the significand path to force its product to zero. The result sign is the exclusive OR of the operand signs. The implicit leading bits for both operands are produced combinationally, because the significand path needs them in the same cycle as its operands. All other results are registered once, so they appear one clock after the inputs are sampled.

Subnormal operands are treated as zero. NaN inputs get no special handling.

Top module: `tre_exp_path`

## Requirements
- R1: Format code `fmt_i` selects the exponent width: 0 selects 5 bits (bias 15), 1 selects 6 bits (bias 31), 2 selects 7 bits (bias 63), and 3 selects 8 bits (bias 127).
- R2: Input exponent bits at position e and above, where e is the selected width, have no effect on any output.
- R3: `imp_a_o` and `imp_b_o` are 0 when the masked exponent field of their operand is zero, and 1 otherwise. They respond in the same cycle as the inputs.
- R4: Let S = A + B − bias + ovf, where A and B are the masked fields. When neither field is zero and 1 ≤ S ≤ 2^e − 2, `exp_o` equals S one clock after the inputs are sampled, and both flags are low.
- R5: When either masked field is zero, or S ≤ 0, `zero_o` is 1 and `exp_o` is 0.
- R6: When neither masked field is zero and S ≥ 2^e − 1, `inf_o` is 1 and `exp_o` holds e ones in its low bits.
- R7: `flush_o` is 1 exactly when `zero_o` or `inf_o` is 1, and `zero_o` and `inf_o` are never both 1.
- R8: `sign_o` is the exclusive OR of the two operand signs, with one clock of latency.
- R9: Bits of `exp_o` at position e and above are always 0.
- R10: While `rst_n` is low, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Exponent width code (0..3 selects 5..8 bits) |
| exp_a_i | input | 8 | Operand A biased exponent field |
| exp_b_i | input | 8 | Operand B biased exponent field |
| sign_a_i | input | 1 | Operand A sign |
| sign_b_i | input | 1 | Operand B sign |
| sig_ovf_i | input | 1 | Significand product overflow, requests the incremented sum |
| imp_a_o | output | 1 | Implicit bit of operand A (combinational) |
| imp_b_o | output | 1 | Implicit bit of operand B (combinational) |
| exp_o | output | 8 | Result exponent (registered) |
| sign_o | output | 1 | Result sign (registered) |
| zero_o | output | 1 | Result is zero (registered) |
| inf_o | output | 1 | Result is infinity (registered) |
| flush_o | output | 1 | Force significand to zero (registered) |

## Verification
The implicit bits are combinational, so the bench samples them 1 ns after it drives the inputs on a falling edge, within the same cycle. Exponent, sign and the three flags are due at the first rising edge after the inputs are applied. The bench computes the expected values from the requirements, queues them, and pops and compares them at the next falling edge, half a period after that rising edge. The queue is compared on every clock while a stimulus stream runs back to back.

// File: rtl/tre_pkg.sv
package tre_pkg;
    localparam int EXP_W  = 8;
    localparam int CODE_W = 2;
    localparam int SUM_W  = EXP_W + 2;
    localparam int MIN_E  = 5;

    typedef enum logic [CODE_W-1:0] {
        FMT_E5 = 2'd0,
        FMT_E6 = 2'd1,
        FMT_E7 = 2'd2,
        FMT_E8 = 2'd3
    } ewid_e;
endpackage

// File: rtl/tre_bias_gen.sv
module tre_bias_gen
    import tre_pkg::*;
#(
    parameter int W = EXP_W
) (
    input  ewid_e         fmt,
    output logic [W-1:0]  bias,
    output logic [W-1:0]  mask
);
    // Bias: low four bits always set, bits 4..6 decoded from the code.
    always_comb begin
        bias      = '0;
        bias[3:0] = 4'hF;
        bias[4]   = fmt[1] | fmt[0];
        bias[5]   = fmt[1];
        bias[6]   = fmt[1] & fmt[0];
    end

    // Field mask: one bit per exponent bit of the selected width.
    always_comb begin
        unique case (fmt)
            FMT_E5: mask = W'(8'h1F);
            FMT_E6: mask = W'(8'h3F);
            FMT_E7: mask = W'(8'h7F);
            FMT_E8: mask = W'(8'hFF);
            default: mask = '0;
        endcase
    end
endmodule

// File: rtl/tre_exp_add.sv
module tre_exp_add
    import tre_pkg::*;
#(
    parameter int W  = EXP_W,
    localparam int SW = W + 2
) (
    input  logic [W-1:0]  fld_a,
    input  logic [W-1:0]  fld_b,
    input  logic [W-1:0]  bias,
    input  logic          ovf,
    output logic [SW-1:0] sum_sel
);
    logic [SW-1:0] sum_base;
    logic [SW-1:0] sum_inc;

    // Both candidates are formed in parallel; overflow only steers the select.
    always_comb begin
        sum_base = {2'b00, fld_a} + {2'b00, fld_b} - {2'b00, bias};
        sum_inc  = sum_base + SW'(1);
        sum_sel  = ovf ? sum_inc : sum_base;
    end
endmodule

// File: rtl/tre_range_chk.sv
module tre_range_chk
    import tre_pkg::*;
#(
    parameter int W  = EXP_W,
    localparam int SW = W + 2
) (
    input  logic [SW-1:0] sum_sel,
    input  logic [W-1:0]  mask,
    input  logic          opnd_zero,
    output logic          is_zero,
    output logic          is_inf,
    output logic [W-1:0]  exp_val
);
    logic signed [SW-1:0] s_sum;
    logic signed [SW-1:0] s_max;

    always_comb begin
        s_sum   = $signed(sum_sel);
        s_max   = $signed({2'b00, mask});
        is_zero = opnd_zero || (s_sum <= 0);
        is_inf  = !is_zero && (s_sum >= s_max);
        if (is_inf)       exp_val = mask;
        else if (is_zero) exp_val = '0;
        else              exp_val = sum_sel[W-1:0] & mask;
    end
endmodule

// File: rtl/tre_exp_path.sv
module tre_exp_path
    import tre_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  fmt_i,
    input  logic [7:0]  exp_a_i,
    input  logic [7:0]  exp_b_i,
    input  logic        sign_a_i,
    input  logic        sign_b_i,
    input  logic        sig_ovf_i,
    output logic        imp_a_o,
    output logic        imp_b_o,
    output logic [7:0]  exp_o,
    output logic        sign_o,
    output logic        zero_o,
    output logic        inf_o,
    output logic        flush_o
);
    ewid_e              fmt;
    logic [EXP_W-1:0]   bias;
    logic [EXP_W-1:0]   mask;
    logic [EXP_W-1:0]   fld_a;
    logic [EXP_W-1:0]   fld_b;
    logic [SUM_W-1:0]   sum_sel;
    logic               nx_zero;
    logic               nx_inf;
    logic [EXP_W-1:0]   nx_exp;

    assign fmt = ewid_e'(fmt_i);

    tre_bias_gen #(.W(EXP_W)) u_bias (
        .fmt  (fmt),
        .bias (bias),
        .mask (mask)
    );

    // Upper bits beyond the chosen width are discarded here.
    assign fld_a   = exp_a_i & mask;
    assign fld_b   = exp_b_i & mask;
    assign imp_a_o = |fld_a;
    assign imp_b_o = |fld_b;

    tre_exp_add #(.W(EXP_W)) u_add (
        .fld_a   (fld_a),
        .fld_b   (fld_b),
        .bias    (bias),
        .ovf     (sig_ovf_i),
        .sum_sel (sum_sel)
    );

    tre_range_chk #(.W(EXP_W)) u_rng (
        .sum_sel   (sum_sel),
        .mask      (mask),
        .opnd_zero (!imp_a_o || !imp_b_o),
        .is_zero   (nx_zero),
        .is_inf    (nx_inf),
        .exp_val   (nx_exp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_o   <= '0;
            sign_o  <= 1'b0;
            zero_o  <= 1'b0;
            inf_o   <= 1'b0;
            flush_o <= 1'b0;
        end else begin
            exp_o   <= nx_exp;
            sign_o  <= sign_a_i ^ sign_b_i;
            zero_o  <= nx_zero;
            inf_o   <= nx_inf;
            flush_o <= nx_zero | nx_inf;
        end
    end
endmodule

// File: rtl/tre_exp_path_chk.sv
module tre_exp_path_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] fmt_i,
    input logic [7:0] exp_a_i,
    input logic [7:0] exp_b_i,
    input logic       sign_a_i,
    input logic       sign_b_i,
    input logic       imp_a_o,
    input logic       imp_b_o,
    input logic [7:0] exp_o,
    input logic       sign_o,
    input logic       zero_o,
    input logic       inf_o,
    input logic       flush_o
);
    logic [1:0] fmt_q;
    logic [7:0] lim_q;

    always_ff @(posedge clk) begin
        if (!rst_n) fmt_q <= 2'd3;
        else        fmt_q <= fmt_i;
    end

    assign lim_q = 8'((16'd1 << (5 + int'(fmt_q))) - 16'd1);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(zero_o && inf_o));

    a_r7_flush_match: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o == (zero_o || inf_o));

    a_r5_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> exp_o == 8'h00);

    a_r6_inf_ones: assert property (@(posedge clk) disable iff (!rst_n)
        inf_o |-> exp_o == lim_q);

    a_r9_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_o & ~lim_q) == 8'h00);

    a_r8_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sign_o == $past(sign_a_i ^ sign_b_i));

    a_r3_imp_a_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_a_i == 8'h00) |-> !imp_a_o);

    a_r3_imp_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_b_i == 8'h00) |-> !imp_b_o);

    a_r3_imp_a_full: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_a_i[4:0] != 5'd0) |-> imp_a_o);
endmodule

bind tre_exp_path tre_exp_path_chk u_chk (.*);

// File: tb/tre_exp_path_tb_top.sv
module tre_exp_path_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fmt_i = '0;
    logic [7:0] exp_a_i = '0;
    logic [7:0] exp_b_i = '0;
    logic       sign_a_i = 1'b0;
    logic       sign_b_i = 1'b0;
    logic       sig_ovf_i = 1'b0;
    logic       imp_a_o, imp_b_o;
    logic [7:0] exp_o;
    logic       sign_o, zero_o, inf_o, flush_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] ex;
        logic       sg;
        logic       zr;
        logic       nf;
        string      tag;
    } exp_t;
    exp_t pend[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tre_exp_path dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i),
        .exp_a_i(exp_a_i), .exp_b_i(exp_b_i),
        .sign_a_i(sign_a_i), .sign_b_i(sign_b_i), .sig_ovf_i(sig_ovf_i),
        .imp_a_o(imp_a_o), .imp_b_o(imp_b_o), .exp_o(exp_o),
        .sign_o(sign_o), .zero_o(zero_o), .inf_o(inf_o), .flush_o(flush_o)
    );

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic exp_t model(int code, int ea, int eb, bit sa, bit sb, bit ovf, string tag);
        exp_t r;
        int e    = 5 + code;
        int lim  = (1 << e) - 1;
        int bias = (1 << (e - 1)) - 1;
        int fa   = ea & lim;
        int fb   = eb & lim;
        int s    = fa + fb - bias + int'(ovf);
        r.sg = sa ^ sb;
        r.tag = tag;
        r.zr = 1'b0; r.nf = 1'b0;
        if (fa == 0 || fb == 0 || s <= 0) begin r.zr = 1'b1; r.ex = 8'h00; end
        else if (s >= lim)               begin r.nf = 1'b1; r.ex = 8'(lim); end
        else                                   r.ex = 8'(s);
        return r;
    endfunction

    // Compares the oldest queued expectation; called at a falling edge.
    task automatic compare_head();
        exp_t x;
        if (pend.size() == 0) return;
        x = pend.pop_front();
        chk({x.tag, " exp_o"}, int'(exp_o), int'(x.ex));
        chk("R8 sign_o", int'(sign_o), int'(x.sg));
        chk("R5 zero_o", int'(zero_o), int'(x.zr));
        chk("R6 inf_o", int'(inf_o), int'(x.nf));
        chk("R7 flush_o", int'(flush_o), int'(x.zr | x.nf));
    endtask

    // Drive one operation at a falling edge; outputs due after the next rise.
    task automatic op(int code, int ea, int eb, bit sa, bit sb, bit ovf, string tag);
        int lim = (1 << (5 + code)) - 1;
        @(negedge clk);
        compare_head();
        fmt_i = 2'(code); exp_a_i = 8'(ea); exp_b_i = 8'(eb);
        sign_a_i = sa; sign_b_i = sb; sig_ovf_i = ovf;
        #1;
        chk("R3 imp_a_o", int'(imp_a_o), int'((ea & lim) != 0));
        chk("R3 imp_b_o", int'(imp_b_o), int'((eb & lim) != 0));
        pend.push_back(model(code, ea, eb, sa, sb, ovf, tag));
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: outputs held at zero under reset, even with busy inputs.
        exp_a_i = 8'd200; exp_b_i = 8'd200; sign_a_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 exp_o", int'(exp_o), 0);
        chk("R10 sign_o", int'(sign_o), 0);
        chk("R10 flags", int'({zero_o, inf_o, flush_o}), 0);
        rst_n = 1'b1;

        // R1/R4: bias per width, normal results.
        op(0, 15, 15, 0, 0, 0, "R1 R4 e5 mid");
        op(1, 31, 40, 1, 0, 0, "R1 R4 e6");
        op(2, 63, 70, 0, 1, 0, "R1 R4 e7");
        op(3, 127, 127, 1, 1, 0, "R1 R4 e8 mid");
        op(3, 200, 100, 0, 0, 1, "R4 e8 ovf");
        op(3, 190, 191, 0, 0, 0, "R4 e8 max normal");
        op(0, 8, 8, 0, 0, 0, "R4 e5 min normal");
        op(0, 8, 7, 0, 0, 1, "R4 e5 ovf rescues");
        // R5: underflow and zero operands.
        op(0, 8, 7, 0, 1, 0, "R5 e5 sum zero");
        op(3, 1, 1, 0, 0, 0, "R5 e8 deep under");
        op(2, 0, 100, 1, 0, 0, "R5 zero operand");
        op(1, 50, 0, 0, 0, 1, "R5 zero operand b");
        // R6: overflow to infinity.
        op(0, 30, 16, 0, 0, 0, "R6 e5 at limit");
        op(3, 190, 191, 1, 0, 1, "R6 e8 ovf pushes");
        op(1, 63, 63, 0, 0, 1, "R6 R9 e6 far over");
        op(2, 127, 127, 0, 0, 0, "R6 R9 e7 over");
        // R2: high bits ignored (fields become zero or small).
        op(0, 8'hE0, 20, 0, 0, 0, "R2 e5 upper only");
        op(0, 8'hEF, 8'hF0 | 16, 0, 0, 0, "R2 e5 mixed");
        op(1, 8'hC5, 8'h9F, 1, 1, 0, "R2 R9 e6 mixed");
        op(2, 8'h80, 8'h80, 0, 0, 0, "R2 e7 upper only");
        // Back-to-back stream with pseudo-random stimulus.
        for (int i = 0; i < 400; i++) begin
            op(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
               int'($urandom_range(0, 255)), 1'($urandom), 1'($urandom),
               1'($urandom), "R4 R9 stream");
        end
        @(negedge clk);
        compare_head();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule